// File: doc/BRIEF.md
# DDR Write Data Capture with Burst Truncation

This block sits on the device side of a double-data-rate memory interface and receives write bursts. When a decoded WRITE command arrives with a bank and an address, the block arms itself. The first rising strobe edge after that starts a four-element burst. The next three strobe edges, rising and falling alike, supply the remaining elements. Each element carries its data word and per-byte mask. The block pairs each element with the column it belongs to and presents it on a single-cycle synchronous array-write port.

Column order within a burst follows a burst-ordering input that is latched with each WRITE. In sequential order the column walks upward from the start column. In interleaved order the start column is XORed with the beat number. Both orders wrap inside the aligned group of four columns. Strobe edges that belong to no burst are dropped and flagged. A WRITE that arrives during a burst either joins the new burst onto the old one without a gap, or cuts the old burst short.

The strobe, data and command inputs all pass through the same two-register stage clocked by the system clock, and strobe edges are detected after that stage. This keeps every input in the same alignment relative to the others.

Top module: `ddr_wcap`

## Requirements
- R1: After reset, `wr_valid`, `pre_req` and `strobe_err` are low.
- R2: The first rising strobe edge that follows a WRITE captures element 0 of the burst. The element appears on the write port as a one-cycle `wr_valid` pulse, three clock edges after the strobe input changes.
- R3: The three strobe edges after element 0 capture elements 1, 2 and 3, alternating falling and rising. Each captured element produces exactly one write.
- R4: With `burst_ilv`=0 (sequential), element k goes to the column whose two low bits are (start+k) mod 4. The column bits above bit 1 are kept from the start column.
- R5: With `burst_ilv`=1 (interleaved), element k goes to the column whose two low bits are start XOR k. The column bits above bit 1 are kept from the start column.
- R6: A strobe edge is ignored when no burst is open, either after the fourth element or before any WRITE. Such an edge produces no write and raises `strobe_err` for one cycle.
- R7: `wr_mask` carries the captured `dm` bits. Bit i set means byte `dq[8i+7:8i]` must not be written. When all mask bits of an element are set, that element produces no `wr_valid`.
- R8: When bit 10 of `cmd_addr` is high, completing the fourth element produces a one-cycle `pre_req` pulse carrying the burst's bank on `pre_bank`. When bit 10 is low, completing the burst produces no `pre_req`.
- R9: A WRITE issued during a burst takes effect at the next rising strobe edge, which becomes element 0 of the new burst. Any falling edge before that rising edge still belongs to the old burst. A burst cut short this way produces no `pre_req`. If the new WRITE is placed before the final pair, the data flow continues without a gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_write | input | 1 | Decoded WRITE command, one cycle |
| cmd_bank | input | 2 | Bank of the WRITE |
| cmd_addr | input | 11 | Address of the WRITE: bits 8:0 are the start column, bit 10 requests precharge |
| burst_ilv | input | 1 | Burst order: 0 sequential, 1 interleaved |
| dqs | input | 1 | Data strobe |
| dq | input | 16 | Write data |
| dm | input | 2 | Per-byte data mask |
| wr_valid | output | 1 | Array write strobe |
| wr_bank | output | 2 | Bank of the array write |
| wr_col | output | 9 | Column of the array write |
| wr_data | output | 16 | Data of the array write |
| wr_mask | output | 2 | Byte mask of the array write |
| pre_req | output | 1 | Precharge request at burst completion |
| pre_bank | output | 2 | Bank for the precharge request |
| strobe_err | output | 1 | Strobe edge seen outside a burst |

## Verification
Every strobe edge that the bench drives reaches the outputs on the third rising clock edge after the drive. That edge is when the write, the error pulse or the precharge pulse appears, and the pulse lasts one cycle. A WRITE needs two clock edges to arm, so the bench drives its first rising strobe one cycle after the command, and it holds each strobe level for two cycles so that detected edges never merge. The bench queues the expected writes in order before it drives each edge. A monitor samples on falling clock edges and compares each `wr_valid` against the head of the queue. Error and precharge pulses are counted and compared after each scenario has had time to drain.

// File: rtl/ddr_wcap_pkg.sv
package ddr_wcap_pkg;

  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } ord_e;

  // low two column bits of beat k within an aligned group of four
  function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                             input logic [1:0] k,
                                             input ord_e ord);
    logic [1:0] r;
    if (ord == ORD_ILV) r = start ^ k;
    else                r = start + k;
    return r;
  endfunction

endpackage

// File: rtl/ddr_wcap_sync.sv
module ddr_wcap_sync #(
  parameter int DQ_W   = 16,
  parameter int DM_W   = 2,
  parameter int BANK_W = 2,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dqs,
  input  logic [DQ_W-1:0]   dq,
  input  logic [DM_W-1:0]   dm,
  input  logic              cmd_write,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              burst_ilv,
  output logic [DQ_W-1:0]   s_dq,
  output logic [DM_W-1:0]   s_dm,
  output logic              s_cmd,
  output logic [BANK_W-1:0] s_bank,
  output logic [ADDR_W-1:0] s_addr,
  output logic              s_ilv,
  output logic              rise,
  output logic              fall
);
  localparam int PW = 1 + DQ_W + DM_W + 1 + BANK_W + ADDR_W + 1;

  logic [PW-1:0] stage [2];
  logic          dqs_prev;
  logic          s_dqs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage[0] <= '0;
      stage[1] <= '0;
      dqs_prev <= 1'b0;
    end else begin
      stage[0] <= {dqs, dq, dm, cmd_write, cmd_bank, cmd_addr, burst_ilv};
      stage[1] <= stage[0];
      dqs_prev <= s_dqs;
    end
  end

  assign {s_dqs, s_dq, s_dm, s_cmd, s_bank, s_addr, s_ilv} = stage[1];
  assign rise = s_dqs & ~dqs_prev;
  assign fall = ~s_dqs & dqs_prev;

endmodule

// File: rtl/ddr_wcap_seq.sv
module ddr_wcap_seq
  import ddr_wcap_pkg::*;
#(
  parameter int DQ_W   = 16,
  parameter int DM_W   = 2,
  parameter int BANK_W = 2,
  parameter int ADDR_W = 11,
  parameter int COL_W  = 9,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              fall,
  input  logic              cmd,
  input  logic [BANK_W-1:0] bank,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ilv,
  input  logic [DQ_W-1:0]   dq,
  input  logic [DM_W-1:0]   dm,
  output logic              cap_fire,
  output logic [BANK_W-1:0] cap_bank,
  output logic [COL_W-1:0]  cap_col,
  output logic [DQ_W-1:0]   cap_data,
  output logic [DM_W-1:0]   cap_mask,
  output logic              done_fire,
  output logic              done_ap,
  output logic [BANK_W-1:0] done_bank,
  output logic              err_fire
);
  // pending command, armed until the next rising strobe
  logic              armed;
  logic [BANK_W-1:0] a_bank;
  logic [COL_W-1:0]  a_col;
  logic              a_ap;
  ord_e              a_ord;
  // open burst
  logic              active;
  logic [1:0]        idx;
  logic [BANK_W-1:0] b_bank;
  logic [COL_W-1:0]  b_col;
  logic              b_ap;
  ord_e              b_ord;

  logic              edge_seen, start_new, cont;
  logic [COL_W-1:0]  base_col;
  logic [1:0]        beat;
  ord_e              cur_ord;

  assign edge_seen = rise | fall;
  assign start_new = rise & armed;
  assign cont      = edge_seen & ~start_new & active;
  assign err_fire  = edge_seen & ~start_new & ~active;
  assign cap_fire  = start_new | cont;

  assign base_col  = start_new ? a_col : b_col;
  assign beat      = start_new ? 2'd0 : idx;
  assign cur_ord   = start_new ? a_ord : b_ord;
  assign cap_bank  = start_new ? a_bank : b_bank;
  assign cap_col   = {base_col[COL_W-1:2], beat_offset(base_col[1:0], beat, cur_ord)};
  assign cap_data  = dq;
  assign cap_mask  = dm;

  assign done_fire = cont & (idx == 2'd3);
  assign done_ap   = b_ap;
  assign done_bank = b_bank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      a_bank <= '0;
      a_col  <= '0;
      a_ap   <= 1'b0;
      a_ord  <= ORD_SEQ;
      active <= 1'b0;
      idx    <= 2'd0;
      b_bank <= '0;
      b_col  <= '0;
      b_ap   <= 1'b0;
      b_ord  <= ORD_SEQ;
    end else begin
      if (start_new) begin
        armed  <= 1'b0;
        active <= 1'b1;
        idx    <= 2'd1;
        b_bank <= a_bank;
        b_col  <= a_col;
        b_ap   <= a_ap;
        b_ord  <= a_ord;
      end else if (cont) begin
        idx <= idx + 2'd1;
        if (idx == 2'd3) active <= 1'b0;
      end
      if (cmd) begin
        armed  <= 1'b1;
        a_bank <= bank;
        a_col  <= addr[COL_W-1:0];
        a_ap   <= addr[AP_BIT];
        a_ord  <= ord_e'(ilv);
      end
    end
  end

  AST_BURST_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (cont && idx == 2'd3 && !start_new) |=> !active); // R3
  AST_FRESH_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_new |=> (active && idx == 2'd1)); // R9

endmodule

// File: rtl/ddr_wcap_port.sv
module ddr_wcap_port #(
  parameter int DQ_W   = 16,
  parameter int DM_W   = 2,
  parameter int BANK_W = 2,
  parameter int COL_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_fire,
  input  logic [BANK_W-1:0] cap_bank,
  input  logic [COL_W-1:0]  cap_col,
  input  logic [DQ_W-1:0]   cap_data,
  input  logic [DM_W-1:0]   cap_mask,
  input  logic              done_fire,
  input  logic              done_ap,
  input  logic [BANK_W-1:0] done_bank,
  input  logic              err_fire,
  output logic              wr_valid,
  output logic [BANK_W-1:0] wr_bank,
  output logic [COL_W-1:0]  wr_col,
  output logic [DQ_W-1:0]   wr_data,
  output logic [DM_W-1:0]   wr_mask,
  output logic              pre_req,
  output logic [BANK_W-1:0] pre_bank,
  output logic              strobe_err
);
  logic all_masked;
  assign all_masked = &cap_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid   <= 1'b0;
      wr_bank    <= '0;
      wr_col     <= '0;
      wr_data    <= '0;
      wr_mask    <= '0;
      pre_req    <= 1'b0;
      pre_bank   <= '0;
      strobe_err <= 1'b0;
    end else begin
      wr_valid   <= cap_fire & ~all_masked;
      if (cap_fire) begin
        wr_bank <= cap_bank;
        wr_col  <= cap_col;
        wr_data <= cap_data;
        wr_mask <= cap_mask;
      end
      pre_req    <= done_fire & done_ap;
      if (done_fire) pre_bank <= done_bank;
      strobe_err <= err_fire;
    end
  end

  AST_MASKED_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_fire && all_masked) |=> !wr_valid); // R7

endmodule

// File: rtl/ddr_wcap.sv
module ddr_wcap #(
  parameter int DQ_W   = 16,
  parameter int DM_W   = 2,
  parameter int BANK_W = 2,
  parameter int ADDR_W = 11,
  parameter int COL_W  = 9,
  parameter int AP_BIT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_write,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              burst_ilv,
  input  logic              dqs,
  input  logic [DQ_W-1:0]   dq,
  input  logic [DM_W-1:0]   dm,
  output logic              wr_valid,
  output logic [BANK_W-1:0] wr_bank,
  output logic [COL_W-1:0]  wr_col,
  output logic [DQ_W-1:0]   wr_data,
  output logic [DM_W-1:0]   wr_mask,
  output logic              pre_req,
  output logic [BANK_W-1:0] pre_bank,
  output logic              strobe_err
);
  logic [DQ_W-1:0]   s_dq;
  logic [DM_W-1:0]   s_dm;
  logic              s_cmd, s_ilv, rise, fall;
  logic [BANK_W-1:0] s_bank;
  logic [ADDR_W-1:0] s_addr;

  logic              cap_fire, done_fire, done_ap, err_fire;
  logic [BANK_W-1:0] cap_bank, done_bank;
  logic [COL_W-1:0]  cap_col;
  logic [DQ_W-1:0]   cap_data;
  logic [DM_W-1:0]   cap_mask;

  ddr_wcap_sync #(.DQ_W(DQ_W), .DM_W(DM_W), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .dqs(dqs), .dq(dq), .dm(dm),
    .cmd_write(cmd_write), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .burst_ilv(burst_ilv),
    .s_dq(s_dq), .s_dm(s_dm), .s_cmd(s_cmd), .s_bank(s_bank), .s_addr(s_addr),
    .s_ilv(s_ilv), .rise(rise), .fall(fall)
  );

  ddr_wcap_seq #(.DQ_W(DQ_W), .DM_W(DM_W), .BANK_W(BANK_W), .ADDR_W(ADDR_W),
                 .COL_W(COL_W), .AP_BIT(AP_BIT)) u_seq (
    .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall), .cmd(s_cmd), .bank(s_bank),
    .addr(s_addr), .ilv(s_ilv), .dq(s_dq), .dm(s_dm),
    .cap_fire(cap_fire), .cap_bank(cap_bank), .cap_col(cap_col), .cap_data(cap_data),
    .cap_mask(cap_mask), .done_fire(done_fire), .done_ap(done_ap), .done_bank(done_bank),
    .err_fire(err_fire)
  );

  ddr_wcap_port #(.DQ_W(DQ_W), .DM_W(DM_W), .BANK_W(BANK_W), .COL_W(COL_W)) u_port (
    .clk(clk), .rst_n(rst_n), .cap_fire(cap_fire), .cap_bank(cap_bank), .cap_col(cap_col),
    .cap_data(cap_data), .cap_mask(cap_mask), .done_fire(done_fire), .done_ap(done_ap),
    .done_bank(done_bank), .err_fire(err_fire),
    .wr_valid(wr_valid), .wr_bank(wr_bank), .wr_col(wr_col), .wr_data(wr_data),
    .wr_mask(wr_mask), .pre_req(pre_req), .pre_bank(pre_bank), .strobe_err(strobe_err)
  );

  AST_WR_FROM_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(cap_fire)); // R2
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_err |-> !wr_valid); // R6
  AST_PRE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    pre_req |-> $past(done_fire && done_ap)); // R8

endmodule

// File: tb/ddr_wcap_tb.sv
module ddr_wcap_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_write = 1'b0;
  logic [1:0]  cmd_bank = '0;
  logic [10:0] cmd_addr = '0;
  logic        burst_ilv = 1'b0;
  logic        dqs = 1'b0;
  logic [15:0] dq = '0;
  logic [1:0]  dm = '0;
  logic        wr_valid, pre_req, strobe_err;
  logic [1:0]  wr_bank, wr_mask, pre_bank;
  logic [8:0]  wr_col;
  logic [15:0] wr_data;

  always #4 clk = ~clk; // 125 MHz

  ddr_wcap u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_write(cmd_write), .cmd_bank(cmd_bank),
    .cmd_addr(cmd_addr), .burst_ilv(burst_ilv), .dqs(dqs), .dq(dq), .dm(dm),
    .wr_valid(wr_valid), .wr_bank(wr_bank), .wr_col(wr_col), .wr_data(wr_data),
    .wr_mask(wr_mask), .pre_req(pre_req), .pre_bank(pre_bank), .strobe_err(strobe_err)
  );

  int compared = 0;
  int mismatched = 0;
  int err_seen = 0, err_exp = 0;
  int pre_seen = 0, pre_exp = 0;
  logic [1:0] pre_bank_exp = '0;
  logic [28:0] exp_q[$]; // {bank, col, data, mask}
  string       tag_q[$];
  logic [1:0]  cur_bank;
  logic [8:0]  cur_col;
  logic        cur_ilv;
  int          cur_k;

  task automatic check(input string rq, input longint act, input longint exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // column of beat k: walk upward or flip bits, inside the aligned group of four
  function automatic logic [8:0] col_of(input logic [8:0] start, input int k, input logic ilv);
    int lo;
    if (ilv) lo = int'(start[1:0]) ^ k;
    else     lo = (int'(start[1:0]) + k) % 4;
    return {start[8:2], 2'(lo)};
  endfunction

  task automatic do_write(input logic [1:0] b, input logic [10:0] a, input logic ilv);
    @(negedge clk);
    cmd_write = 1'b1; cmd_bank = b; cmd_addr = a; burst_ilv = ilv;
    cur_bank = b; cur_col = a[8:0]; cur_ilv = ilv; cur_k = 0;
    @(negedge clk);
    cmd_write = 1'b0;
  endtask

  // drive one strobe edge; expect tells whether the element belongs to the current burst
  task automatic strobe(input logic [15:0] d, input logic [1:0] m, input bit expect_wr,
                        input string rq);
    if (expect_wr) begin
      if (m != 2'b11) begin
        exp_q.push_back({cur_bank, col_of(cur_col, cur_k, cur_ilv), d, m});
        tag_q.push_back(rq);
      end
      cur_k++;
    end else begin
      err_exp++;
    end
    dq = d; dm = m; dqs = ~dqs;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic drain(input string rq);
    repeat (6) @(negedge clk);
    check({rq, " pending writes"}, exp_q.size(), 0);
    check({rq, " strobe_err count"}, err_seen, err_exp);
    check({rq, " pre_req count"}, pre_seen, pre_exp);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_valid) begin
        if (exp_q.size() == 0) begin
          check("R6 unexpected write", 1, 0);
        end else begin
          logic [28:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, {wr_bank, wr_col, wr_data, wr_mask}, e);
        end
      end
      if (strobe_err) err_seen++;
      if (pre_req) begin
        pre_seen++;
        check("R8 pre_bank", pre_bank, pre_bank_exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 wr_valid reset", wr_valid, 0);
    check("R1 pre_req reset", pre_req, 0);
    check("R1 strobe_err reset", strobe_err, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R6: edges before any WRITE
    strobe(16'hDEAD, 2'b00, 0, "R6");
    strobe(16'hBEEF, 2'b00, 0, "R6");
    drain("R6 pre-write");

    // R2 R3 R4: sequential from column 5, AP low
    do_write(2'd1, 11'h005, 1'b0);
    strobe(16'h1111, 2'b00, 1, "R2 seq e0");
    strobe(16'h2222, 2'b00, 1, "R3 R4 seq e1");
    strobe(16'h3333, 2'b00, 1, "R4 seq e2");
    strobe(16'h4444, 2'b00, 1, "R4 seq e3 wrap");
    drain("R8 AP low");
    // R6: edges after completed burst
    strobe(16'h5555, 2'b00, 0, "R6");
    strobe(16'h6666, 2'b00, 0, "R6");
    drain("R6 post-burst");

    // R5 R8: interleaved from column 0x0E6, AP high
    pre_bank_exp = 2'd2; pre_exp++;
    do_write(2'd2, 11'h4E6, 1'b1);
    strobe(16'hA001, 2'b00, 1, "R5 ilv e0");
    strobe(16'hA002, 2'b00, 1, "R5 ilv e1");
    strobe(16'hA003, 2'b00, 1, "R5 ilv e2");
    strobe(16'hA004, 2'b00, 1, "R5 ilv e3");
    drain("R8 AP high");

    // R7: masks
    do_write(2'd3, 11'h103, 1'b0);
    strobe(16'hB001, 2'b01, 1, "R7 low byte masked");
    strobe(16'hB002, 2'b11, 1, "R7 fully masked");
    strobe(16'hB003, 2'b10, 1, "R7 high byte masked");
    strobe(16'hB004, 2'b00, 1, "R7 unmasked");
    drain("R7");

    // R9: truncation after two elements; old burst had AP, new one does not
    do_write(2'd0, 11'h409, 1'b0);
    strobe(16'hC001, 2'b00, 1, "R9 old e0");
    strobe(16'hC002, 2'b00, 1, "R9 old e1");
    do_write(2'd1, 11'h012, 1'b1);
    strobe(16'hC101, 2'b00, 1, "R9 new e0");
    strobe(16'hC102, 2'b00, 1, "R9 new e1");
    strobe(16'hC103, 2'b00, 1, "R9 new e2");
    strobe(16'hC104, 2'b00, 1, "R9 new e3");
    drain("R9 truncate");

    // R9: concatenation, new WRITE placed before the final falling edge
    pre_bank_exp = 2'd3; pre_exp++;
    do_write(2'd3, 11'h420, 1'b0);
    strobe(16'hD001, 2'b00, 1, "R9 join e0");
    strobe(16'hD002, 2'b00, 1, "R9 join e1");
    strobe(16'hD003, 2'b00, 1, "R9 join e2");
    do_write(2'd2, 11'h031, 1'b1); // model keeps cur_* of new burst; old e3 pushed below
    begin
      // old burst final element still goes to old burst
      exp_q.push_back({2'd3, col_of(9'h020, 3, 1'b0), 16'hD004, 2'b00});
      tag_q.push_back("R9 join old e3");
      dq = 16'hD004; dm = 2'b00; dqs = ~dqs;
      @(negedge clk); @(negedge clk);
    end
    strobe(16'hE001, 2'b00, 1, "R9 join new e0");
    strobe(16'hE002, 2'b00, 1, "R9 join new e1");
    strobe(16'hE003, 2'b00, 1, "R9 join new e2");
    strobe(16'hE004, 2'b00, 1, "R9 join new e3");
    drain("R9 concatenate");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule